// File: doc/BRIEF.md
# Dual-Clock Bus-Matching FIFO

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. Each side has its own active-low enable. The write port and the read port are each set to 18 or 9 bits wide, independently of one another. The block therefore handles four transfer shapes and converts between them. All storage and pointer arithmetic works in 9-bit half-words. An endian input decides which half of an 18-bit bus word counts as the earlier half in the stream.

The read side offers two timing modes. In standard timing a word is fetched into the output register on a read edge. In first-word-fall-through timing the head word moves into the output register by itself, and the empty flag then means "no word ready". The block has a full flag and an empty flag. It also has an almost-empty flag and an almost-full flag, each with its own threshold.

The widths, the endian choice, the timing mode and both thresholds are taken from the inputs while the master reset is held low. A partial reset empties the buffer and clears its flags. It keeps that captured setup.

Top module: `bmf_top`

## Requirements
- R1: With both ports 9 bits wide, data leaves in the order it was written. Bits [8:0] of the write bus are stored and bits [17:9] are ignored. A 9-bit read drives dout_o[17:9] to zero.
- R2: With an 18-bit write and a 9-bit read, each write yields two half-word reads. With a 9-bit write and an 18-bit read, two writes yield one read. The half-word stream order is preserved.
- R3: With big_end_i=1, bits [17:9] of an 18-bit bus word are the earlier half-word. With big_end_i=0, bits [8:0] are the earlier half-word.
- R4: full_o is high when a further write of the configured width would not fit in the memory. A write while full_o is high changes nothing.
- R5: In standard mode, empty_o is high while fewer half-words are stored than one read-width word needs, so a lone half-word in 18-bit read mode keeps it high. A read while empty_o is high changes nothing.
- R6: almost_empty_o is high when the stored half-word count is at most ae_off_i.
- R7: almost_full_o is high when the stored half-word count is at least DEPTH_HW minus af_off_i.
- R8: With fwft_i=1, the head word appears on dout_o without a read request, and empty_o is low exactly while dout_o holds an unread word. In this mode the memory count excludes the word held at the output.
- R9: Pulling prs_ni low empties the buffer and clears the flags, while keeping the thresholds captured at master reset.
- R10: Widths, endian, timing mode and thresholds are sampled while rst_ni is low and are ignored afterwards. After reset, empty_o and almost_empty_o are high and the other two flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | write clock |
| rclk_i | input | 1 | read clock |
| rst_ni | input | 1 | master reset, active low, asynchronous; samples the setup inputs |
| prs_ni | input | 1 | partial reset, active low, asynchronous |
| iw18_i | input | 1 | write port 18 bits wide when 1, else 9 |
| ow18_i | input | 1 | read port 18 bits wide when 1, else 9 |
| big_end_i | input | 1 | upper half of an 18-bit word is the earlier half when 1 |
| fwft_i | input | 1 | first-word-fall-through timing when 1 |
| ae_off_i | input | OFF_W | almost-empty threshold in half-words |
| af_off_i | input | OFF_W | almost-full threshold in half-words |
| wen_ni | input | 1 | write enable, active low |
| din_i | input | 2*HALF_W | write data |
| ren_ni | input | 1 | read enable, active low |
| dout_o | output | 2*HALF_W | read data register |
| empty_o | output | 1 | empty, or no word ready in fall-through mode |
| full_o | output | 1 | full, or not able to take a write |
| almost_empty_o | output | 1 | fill at or below the empty threshold |
| almost_full_o | output | 1 | fill at or above the full threshold |

## Verification
The bench sweeps all sixteen combinations of write width, read width, endian and timing mode. It fills the memory one write at a time, including writes past full. After each write it checks all four flags against an arithmetic fill model. This catches an off-by-one threshold, a full flag that ignores the write width, and a fall-through output word that is wrongly counted in the memory level. Draining every word and comparing it with an independently built half-word stream exposes swapped halves, lost or duplicated half-words at width changes, and an overflow that overwrote the head. A separate pass changes the setup inputs after master reset, issues a partial reset and reads while empty. A design that took live setup inputs, lost its thresholds, or moved its read pointer on underflow would return wrong data or wrong flags there.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
  localparam int HALF_W_DEF = 9;

  typedef struct packed {
    logic iw18;
    logic ow18;
    logic big_end;
    logic fwft;
  } bmf_cfg_t;
endpackage

// File: rtl/bmf_sync.sv
// two-flop synchronizer for a Gray pointer, binary result
module bmf_sync #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         clr_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_o[W-1] = sync_q[W-1];
    for (int i = W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/bmf_mem.sv
module bmf_mem #(
  parameter int HALF_W = 9,
  parameter int WORDS  = 16,
  localparam int AWW   = $clog2(WORDS)
) (
  input  logic                wclk_i,
  input  logic [1:0]          we_i,
  input  logic [AWW-1:0]      waddr_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  input  logic [AWW-1:0]      raddr_i,
  output logic [2*HALF_W-1:0] rdata_o
);
  // lane 0 holds the even half-word, lane 1 the odd one
  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [HALF_W-1:0] arr [WORDS];
    always_ff @(posedge wclk_i) begin
      if (we_i[l]) arr[waddr_i] <= wdata_i[l*HALF_W +: HALF_W];
    end
    assign rdata_o[l*HALF_W +: HALF_W] = arr[raddr_i];
  end
endmodule

// File: rtl/bmf_wr.sv
module bmf_wr #(
  parameter int DEPTH_HW = 32,
  parameter int HALF_W   = 9,
  parameter int OFF_W    = 5,
  localparam int AW      = $clog2(DEPTH_HW) + 1,
  localparam int DW      = 2 * HALF_W
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             prs_ni,
  input  logic             iw18_i,
  input  logic             ow18_i,
  input  logic             big_end_i,
  input  logic [OFF_W-1:0] af_off_i,
  input  logic             wen_ni,
  input  logic [DW-1:0]    din_i,
  input  logic [AW-1:0]    rbin_s_i,
  output logic [1:0]       we_o,
  output logic [AW-2:0]    waddr_o,
  output logic [DW-1:0]    wdata_o,
  output logic [AW-1:0]    wgray_o,
  output logic             full_o,
  output logic             almost_full_o
);
  logic             iw18_q, ow18_q, be_q;
  logic [OFF_W-1:0] af_q;
  logic             clr_n;
  logic [AW-1:0]    wptr_q, wptr_nxt, wstep, rptr_w, fill, half_nxt;
  logic [AW:0]      need;
  logic             push;
  logic [HALF_W-1:0] first_h, second_h;

  assign clr_n = rst_ni & prs_ni;

  // setup is captured only during master reset
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iw18_q <= iw18_i;
      ow18_q <= ow18_i;
      be_q   <= big_end_i;
      af_q   <= af_off_i;
    end
  end

  assign wstep   = iw18_q ? AW'(2) : AW'(1);
  assign rptr_w  = ow18_q ? {rbin_s_i[AW-2:0], 1'b0} : rbin_s_i;
  assign fill    = wptr_q - rptr_w;
  assign need    = {1'b0, fill} + {1'b0, wstep};
  assign full_o  = need > (AW+1)'(DEPTH_HW);
  assign almost_full_o = fill >= (AW'(DEPTH_HW) - AW'(af_q));
  assign push    = !wen_ni && !full_o;
  assign wptr_nxt = wptr_q + wstep;
  // an 18-bit side moves its pointer in word units across the boundary
  assign half_nxt = iw18_q ? {1'b0, wptr_nxt[AW-1:1]} : wptr_nxt;

  always_ff @(posedge wclk_i or negedge clr_n) begin
    if (!clr_n) begin
      wptr_q  <= '0;
      wgray_o <= '0;
    end else if (push) begin
      wptr_q  <= wptr_nxt;
      wgray_o <= half_nxt ^ (half_nxt >> 1);
    end
  end

  assign first_h  = be_q ? din_i[DW-1:HALF_W] : din_i[HALF_W-1:0];
  assign second_h = be_q ? din_i[HALF_W-1:0]  : din_i[DW-1:HALF_W];

  always_comb begin
    if (iw18_q) begin
      wdata_o = {second_h, first_h};
      we_o    = push ? 2'b11 : 2'b00;
    end else begin
      wdata_o = {din_i[HALF_W-1:0], din_i[HALF_W-1:0]};
      we_o    = push ? (wptr_q[0] ? 2'b10 : 2'b01) : 2'b00;
    end
  end
  assign waddr_o = wptr_q[AW-2:1];

  p_no_overflow_r4: assert property (@(posedge wclk_i) disable iff (!clr_n)
    (full_o && !wen_ni) |=> $stable(wptr_q));
  p_fill_bound_r4: assert property (@(posedge wclk_i) disable iff (!clr_n)
    fill <= AW'(DEPTH_HW));
  p_word_aligned_r2: assert property (@(posedge wclk_i) disable iff (!clr_n)
    iw18_q |-> !wptr_q[0]);
endmodule

// File: rtl/bmf_rd.sv
module bmf_rd
  import bmf_pkg::*;
#(
  parameter int DEPTH_HW = 32,
  parameter int HALF_W   = 9,
  parameter int OFF_W    = 5,
  localparam int AW      = $clog2(DEPTH_HW) + 1,
  localparam int DW      = 2 * HALF_W
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             prs_ni,
  input  bmf_cfg_t         cfg_i,
  input  logic [OFF_W-1:0] ae_off_i,
  input  logic             ren_ni,
  input  logic [AW-1:0]    wbin_s_i,
  input  logic [DW-1:0]    rdata_i,
  output logic [AW-2:0]    raddr_o,
  output logic [AW-1:0]    rgray_o,
  output logic [DW-1:0]    dout_o,
  output logic             empty_o,
  output logic             almost_empty_o
);
  bmf_cfg_t         cfg_q;
  logic [OFF_W-1:0] ae_q;
  logic             clr_n;
  logic [AW-1:0]    rptr_q, rptr_nxt, rstep, wptr_r, fill, half_nxt;
  logic             avail, load, out_vld_q;
  logic [HALF_W-1:0] lane0, lane1;
  logic [DW-1:0]    word;

  assign clr_n = rst_ni & prs_ni;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= cfg_i;
      ae_q  <= ae_off_i;
    end
  end

  assign rstep  = cfg_q.ow18 ? AW'(2) : AW'(1);
  assign wptr_r = cfg_q.iw18 ? {wbin_s_i[AW-2:0], 1'b0} : wbin_s_i;
  assign fill   = wptr_r - rptr_q;
  assign avail  = fill >= rstep;
  assign rptr_nxt = rptr_q + rstep;
  assign half_nxt = cfg_q.ow18 ? {1'b0, rptr_nxt[AW-1:1]} : rptr_nxt;

  assign lane0 = rdata_i[HALF_W-1:0];
  assign lane1 = rdata_i[DW-1:HALF_W];
  always_comb begin
    if (cfg_q.ow18) word = cfg_q.big_end ? {lane0, lane1} : {lane1, lane0};
    else            word = {{HALF_W{1'b0}}, rptr_q[0] ? lane1 : lane0};
  end

  // fall-through refills the output register whenever it is free or being read
  assign load = cfg_q.fwft ? (avail && (!out_vld_q || !ren_ni)) : (avail && !ren_ni);

  always_ff @(posedge rclk_i or negedge clr_n) begin
    if (!clr_n) begin
      rptr_q    <= '0;
      rgray_o   <= '0;
      dout_o    <= '0;
      out_vld_q <= 1'b0;
    end else if (load) begin
      rptr_q    <= rptr_nxt;
      rgray_o   <= half_nxt ^ (half_nxt >> 1);
      dout_o    <= word;
      out_vld_q <= 1'b1;
    end else if (!ren_ni) begin
      out_vld_q <= 1'b0;
    end
  end

  assign raddr_o        = rptr_q[AW-2:1];
  assign empty_o        = cfg_q.fwft ? !out_vld_q : !avail;
  assign almost_empty_o = fill <= AW'(ae_q);

  p_no_underflow_r5: assert property (@(posedge rclk_i) disable iff (!clr_n)
    (!cfg_q.fwft && !avail && !ren_ni) |=> $stable(rptr_q));
  p_fill_bound_r5: assert property (@(posedge rclk_i) disable iff (!clr_n)
    fill <= AW'(DEPTH_HW));
  p_fwft_hold_r8: assert property (@(posedge rclk_i) disable iff (!clr_n)
    (cfg_q.fwft && out_vld_q && ren_ni) |=> ($stable(dout_o) && out_vld_q));
endmodule

// File: rtl/bmf_top.sv
module bmf_top
  import bmf_pkg::*;
#(
  parameter int DEPTH_HW = 32,
  parameter int HALF_W   = HALF_W_DEF,
  parameter int OFF_W    = 5,
  localparam int AW      = $clog2(DEPTH_HW) + 1,
  localparam int DW      = 2 * HALF_W,
  localparam int WORDS   = DEPTH_HW / 2
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             prs_ni,
  input  logic             iw18_i,
  input  logic             ow18_i,
  input  logic             big_end_i,
  input  logic             fwft_i,
  input  logic [OFF_W-1:0] ae_off_i,
  input  logic [OFF_W-1:0] af_off_i,
  input  logic             wen_ni,
  input  logic [DW-1:0]    din_i,
  input  logic             ren_ni,
  output logic [DW-1:0]    dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             almost_empty_o,
  output logic             almost_full_o
);
  bmf_cfg_t      cfg;
  logic          clr_n;
  logic [1:0]    we;
  logic [AW-2:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;
  logic [AW-1:0] wgray, rgray, wbin_s, rbin_s;

  assign clr_n = rst_ni & prs_ni;
  assign cfg   = '{iw18: iw18_i, ow18: ow18_i, big_end: big_end_i, fwft: fwft_i};

  bmf_wr #(.DEPTH_HW(DEPTH_HW), .HALF_W(HALF_W), .OFF_W(OFF_W)) u_wr (
    .wclk_i, .rst_ni, .prs_ni, .iw18_i, .ow18_i, .big_end_i, .af_off_i,
    .wen_ni, .din_i, .rbin_s_i(rbin_s), .we_o(we), .waddr_o(waddr),
    .wdata_o(wdata), .wgray_o(wgray), .full_o, .almost_full_o
  );

  bmf_mem #(.HALF_W(HALF_W), .WORDS(WORDS)) u_mem (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  bmf_sync #(.W(AW)) u_sync_w2r (.clk_i(rclk_i), .clr_ni(clr_n), .gray_i(wgray), .bin_o(wbin_s));
  bmf_sync #(.W(AW)) u_sync_r2w (.clk_i(wclk_i), .clr_ni(clr_n), .gray_i(rgray), .bin_o(rbin_s));

  bmf_rd #(.DEPTH_HW(DEPTH_HW), .HALF_W(HALF_W), .OFF_W(OFF_W)) u_rd (
    .rclk_i, .rst_ni, .prs_ni, .cfg_i(cfg), .ae_off_i, .ren_ni,
    .wbin_s_i(wbin_s), .rdata_i(rdata), .raddr_o(raddr), .rgray_o(rgray),
    .dout_o, .empty_o, .almost_empty_o
  );
endmodule

// File: tb/bmf_top_tb_top.sv
module bmf_top_tb_top;
  localparam int DEPTH = 32;
  localparam int HW    = 9;
  localparam int DW    = 18;
  localparam int OFW   = 5;

  logic wclk = 1'b0, rclk = 1'b0;
  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  logic rst_n = 1'b0, prs_n = 1'b1;
  logic iw18 = 1'b0, ow18 = 1'b0, be = 1'b0, fwft = 1'b0;
  logic [OFW-1:0] ae_off = 5'd7, af_off = 5'd7;
  logic wen_n = 1'b1, ren_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic empty, full, aempty, afull;

  int checks = 0, errs = 0, base = 0, written = 0;

  bmf_top #(.DEPTH_HW(DEPTH), .HALF_W(HW), .OFF_W(OFW)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prs_ni(prs_n),
    .iw18_i(iw18), .ow18_i(ow18), .big_end_i(be), .fwft_i(fwft),
    .ae_off_i(ae_off), .af_off_i(af_off), .wen_ni(wen_n), .din_i(din),
    .ren_ni(ren_n), .dout_o(dout), .empty_o(empty), .full_o(full),
    .almost_empty_o(aempty), .almost_full_o(afull)
  );

  function automatic logic [HW-1:0] hv(int k);
    return HW'((k + base) * 37 + 5);
  endfunction

  function automatic logic [DW-1:0] pack(bit wide, bit big, int p);
    if (!wide) return {HW'(0), hv(p)};
    return big ? {hv(p), hv(p + 1)} : {hv(p + 1), hv(p)};
  endfunction

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chkw(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic master_reset(bit i, bit o, bit b, bit f, int ae, int af);
    wen_n = 1'b1; ren_n = 1'b1; prs_n = 1'b1;
    rst_n = 1'b0;
    iw18 = i; ow18 = o; be = b; fwft = f;
    ae_off = OFW'(ae); af_off = OFW'(af);
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    repeat (3) @(negedge wclk);
    chk1("R10 reset empty", empty, 1'b1);
    chk1("R10 reset full", full, 1'b0);
    chk1("R10 reset almost-empty", aempty, 1'b1);
    chk1("R10 reset almost-full", afull, 1'b0);
  endtask

  task automatic write_word(bit wide, bit big);
    @(negedge wclk);
    din   = wide ? (big ? {hv(written), hv(written + 1)} : {hv(written + 1), hv(written)})
                 : {9'h1AA, hv(written)};
    wen_n = 1'b0;
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic read_words(int n, bit wide, bit big, bit f, string tag);
    @(negedge rclk);
    ren_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (f) chkw(tag, dout, pack(wide, big, wide ? 2 * i : i));
      @(negedge rclk);
      if (!f) chkw(tag, dout, pack(wide, big, wide ? 2 * i : i));
    end
    ren_n = 1'b1;
  endtask

  task automatic run_cfg(bit i, bit o, bit b, bit f, int idx);
    int ws, rs, fillw;
    bit acc;
    ws = i ? 2 : 1;
    rs = o ? 2 : 1;
    base = idx * 5;
    master_reset(i, o, b, f, 7, 7);
    written = 0;
    for (int a = 0; a < DEPTH / ws + 3; a++) begin
      fillw = written - ((f && written >= rs) ? rs : 0);
      acc = (fillw + ws <= DEPTH);
      write_word(i, b);
      if (acc) written += ws;
      repeat (12) @(negedge wclk);
      fillw = written - ((f && written >= rs) ? rs : 0);
      chk1("R4 full level", full, fillw + ws > DEPTH);
      chk1("R7 almost-full level", afull, fillw >= DEPTH - 7);
      if (f) chk1("R8 fall-through ready", empty, written < rs);
      else   chk1("R5 empty level", empty, fillw < rs);
      chk1("R6 almost-empty level", aempty, fillw <= 7);
    end
    // R1 R2 R3 R8: drain and compare against the half-word stream
    read_words(written / rs, o, b, f, "R1 R2 R3 R8 data");
    repeat (12) @(negedge wclk);
    chk1("R5 empty after drain", empty, 1'b1);
    chk1("R6 almost-empty after drain", aempty, 1'b1);
    chk1("R4 full after drain", full, 1'b0);
    chk1("R7 almost-full after drain", afull, 1'b0);
  endtask

  task automatic partial_reset_test();
    master_reset(0, 0, 0, 0, 3, 3);
    // R10: setup inputs changed after master reset must have no effect
    iw18 = 1'b1; ow18 = 1'b1; fwft = 1'b1; be = 1'b1;
    ae_off = 5'd20; af_off = 5'd20;
    base = 100;
    written = 0;
    for (int k = 0; k < 5; k++) begin
      write_word(0, 0);
      written++;
    end
    repeat (12) @(negedge wclk);
    chk1("R10 almost-empty uses captured offset", aempty, 1'b0);
    chk1("R10 almost-full uses captured offset", afull, 1'b0);
    chk1("R10 standard mode kept", empty, 1'b0);
    @(negedge wclk);
    prs_n = 1'b0;
    repeat (2) @(negedge wclk);
    prs_n = 1'b1;
    repeat (4) @(negedge wclk);
    chk1("R9 empty after partial reset", empty, 1'b1);
    chk1("R9 full after partial reset", full, 1'b0);
    chk1("R9 almost-empty after partial reset", aempty, 1'b1);
    chk1("R9 almost-full after partial reset", afull, 1'b0);
    // R5: reads while empty must not move the read side
    @(negedge rclk);
    ren_n = 1'b0;
    repeat (3) @(negedge rclk);
    ren_n = 1'b1;
    chk1("R5 empty after underflow attempt", empty, 1'b1);
    base = 200;
    written = 0;
    for (int k = 0; k < 5; k++) begin
      write_word(0, 0);
      written++;
    end
    repeat (12) @(negedge wclk);
    chk1("R9 offset kept through partial reset", aempty, 1'b0);
    chk1("R5 not empty after refill", empty, 1'b0);
    read_words(5, 0, 0, 0, "R5 R9 R10 data after partial reset");
  endtask

  initial begin
    for (int c = 0; c < 16; c++) run_cfg(c[3], c[2], c[1], c[0], c);
    partial_reset_test();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule